// File: doc/BRIEF.md
# Dual-Gain Auto-Range Sample Selector

This block sits on a tagged stream of converter results, downstream of a scan sequencer that has been programmed to read some channels twice in a row: first at unity gain, then at a gain of ten. It keeps the unity-gain reading until the high-gain partner arrives. It then emits one sample for the pair, together with a flag naming the gain behind it. The choice is made only after both readings exist, so no gain has to be guessed in advance. A small unity reading means the amplified one is the more precise. A large unity reading means the amplified one may have clipped, so the unity reading is kept.

Samples that are not pair members flow straight through. A broken pair ends in one of three ways: the partner carries a different channel, an ordinary sample cuts in, or a high-gain member arrives with nothing held. In each case the reading on hand is emitted alone with an error flag, and the stream keeps moving. Both sides use valid/ready handshakes. A single output register stalls the input while its result is unaccepted.

Top module: `autorange_pair_sel`

## Requirements
- R1: After reset no reading is held and out_valid is 0; a high-gain pair member arriving first is therefore treated as an orphan (R8).
- R2: A sample with in_pair=0 and no reading held is emitted with the same data and channel, out_range equal to its in_gain bit, and out_err=0.
- R3: A sample with in_pair=1 and in_gain=0 (unity, encoding 0) is held and produces no output. The following in_pair=1, in_gain=1 (times ten, encoding 1) sample of the same channel closes the pair with exactly one output carrying that channel.
- R4: With data width W, the threshold is floor((2^(W-1)-1)/10), which is 204 for W=12. When the magnitude of the held two's-complement unity reading is strictly below this threshold, the high-gain reading is emitted with out_range=1 and out_err=0.
- R5: Otherwise the unity reading is emitted with out_range=0 and out_err=0. This includes a magnitude equal to the threshold and the most negative code.
- R6: If a reading is held and the next sample is a high-gain member of another channel, the held reading is emitted alone with out_err=1 and out_range=0. The arriving sample is not consumed in that cycle and is then handled as if no reading were held.
- R7: A sample with in_pair=0 arriving while a reading is held behaves as in R6: the held reading goes out flagged, then the sample passes through.
- R8: A sample with in_pair=1 and in_gain=1 and no reading held is emitted alone with out_range=1 and out_err=1.
- R9: While out_valid=1 and out_ready=0, every output stays stable and no sample that would produce output is accepted. No result is lost or duplicated under any out_ready pattern.
- R10: A result appears on the outputs in the cycle after the clock edge that accepts its last input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample accepted on this edge |
| in_data | input | DATA_W | Two's-complement reading |
| in_chan | input | CH_W | Channel tag |
| in_gain | input | 1 | Gain tag: 0 unity, 1 times ten |
| in_pair | input | 1 | Sample is a member of a dual-gain pair |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | DATA_W | Chosen or passed reading |
| out_chan | output | CH_W | Channel of the result |
| out_range | output | 1 | Gain behind the result: 0 unity, 1 times ten |
| out_err | output | 1 | Result comes from a broken pair |

## Verification
A stale or wrongly cleared held reading shows at the ports within one or two samples. Either a pair closes with the wrong channel or data, or a flagged error result appears where a clean pair was sent. A threshold compare that is off by one or mishandles the sign only shows on readings at exactly ±204 and on the most negative code, so those values are driven on purpose. A slip in the ready logic shows as a lost or repeated result in the scoreboard, often many samples after it happens, when out_ready is toggled irregularly.

// File: rtl/ar_pkg.sv
package ar_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_PASS,
    ACT_HOLD,
    ACT_ORPHAN,
    ACT_RESOLVE,
    ACT_FLUSH
  } act_e;

  localparam logic GAIN_UNITY = 1'b0;
  localparam logic GAIN_X10   = 1'b1;
endpackage

// File: rtl/ar_pick.sv
module ar_pick #(
  parameter int DATA_W = 12
) (
  input  logic signed [DATA_W-1:0] first_data,
  input  logic signed [DATA_W-1:0] second_data,
  output logic signed [DATA_W-1:0] pick_data,
  output logic                     pick_range,
  output logic                     below_thr
);
  localparam int unsigned FS_MAG = (2 ** (DATA_W - 1)) - 1;
  localparam int unsigned THR    = FS_MAG / 10;
  localparam logic [DATA_W-1:0] THR_V = DATA_W'(THR);

  // magnitude of a two's-complement code; the most negative code maps to 2^(W-1)
  function automatic logic [DATA_W-1:0] mag_of(input logic signed [DATA_W-1:0] v);
    logic [DATA_W-1:0] u;
    u = v;
    return u[DATA_W-1] ? (~u + 1'b1) : u;
  endfunction

  always_comb begin
    below_thr  = mag_of(first_data) < THR_V;
    pick_range = below_thr ? ar_pkg::GAIN_X10 : ar_pkg::GAIN_UNITY;
    pick_data  = below_thr ? second_data : first_data;
  end
endmodule

// File: rtl/ar_pair_ctrl.sv
module ar_pair_ctrl #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [CH_W-1:0]          in_chan,
  input  logic                     in_gain,
  input  logic                     in_pair,
  input  logic                     slot_free,
  output logic                     in_ready,
  output logic                     emit,
  output ar_pkg::act_e             act,
  output logic                     held_vld,
  output logic signed [DATA_W-1:0] held_data,
  output logic [CH_W-1:0]          held_chan
);
  import ar_pkg::*;

  logic chan_match;
  logic accept;

  always_comb begin
    chan_match = in_chan == held_chan;
    act = ACT_NONE;
    if (in_valid) begin
      if (!held_vld) begin
        if (!in_pair)                 act = ACT_PASS;
        else if (in_gain == GAIN_X10) act = ACT_ORPHAN;
        else                          act = ACT_HOLD;
      end else begin
        if (in_pair && in_gain == GAIN_X10 && chan_match) act = ACT_RESOLVE;
        else                                              act = ACT_FLUSH;
      end
    end
  end

  always_comb begin
    in_ready = (act == ACT_HOLD) ||
               (slot_free && (act == ACT_PASS || act == ACT_ORPHAN || act == ACT_RESOLVE));
    emit     = slot_free && (act == ACT_PASS || act == ACT_ORPHAN ||
                             act == ACT_RESOLVE || act == ACT_FLUSH);
    accept   = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld  <= 1'b0;
      held_data <= '0;
      held_chan <= '0;
    end else if (accept && act == ACT_HOLD) begin
      held_vld  <= 1'b1;
      held_data <= in_data;
      held_chan <= in_chan;
    end else if ((accept && act == ACT_RESOLVE) || (emit && act == ACT_FLUSH)) begin
      held_vld  <= 1'b0;
    end
  end

  AST_HOLD_ONLY_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_vld) |-> $past(in_pair && in_gain == GAIN_UNITY && in_valid)); // R3
  AST_FLUSH_KEEPS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_FLUSH |-> !in_ready); // R6
endmodule

// File: rtl/ar_out_stage.sv
module ar_out_stage #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] ld_data,
  input  logic [CH_W-1:0]          ld_chan,
  input  logic                     ld_range,
  input  logic                     ld_err,
  input  logic                     out_ready,
  output logic                     slot_free,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic [CH_W-1:0]          out_chan,
  output logic                     out_range,
  output logic                     out_err
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
      out_range <= 1'b0;
      out_err   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_chan  <= ld_chan;
      out_range <= ld_range;
      out_err   <= ld_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan) &&
                                $stable(out_range) && $stable(out_err)); // R9
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> slot_free); // R9
endmodule

// File: rtl/autorange_pair_sel.sv
module autorange_pair_sel #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [CH_W-1:0]          in_chan,
  input  logic                     in_gain,
  input  logic                     in_pair,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data,
  output logic [CH_W-1:0]          out_chan,
  output logic                     out_range,
  output logic                     out_err
);
  import ar_pkg::*;

  act_e                     act;
  logic                     emit;
  logic                     slot_free;
  logic                     held_vld;
  logic signed [DATA_W-1:0] held_data;
  logic [CH_W-1:0]          held_chan;
  logic signed [DATA_W-1:0] pick_data;
  logic                     pick_range;
  logic                     below_thr;
  logic signed [DATA_W-1:0] ld_data;
  logic [CH_W-1:0]          ld_chan;
  logic                     ld_range;
  logic                     ld_err;

  // named events for the checks below
  logic pass_fire, resolve_fire, flush_fire, orphan_fire;

  ar_pair_ctrl #(.DATA_W(DATA_W), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_chan(in_chan), .in_gain(in_gain), .in_pair(in_pair),
    .slot_free(slot_free), .in_ready(in_ready), .emit(emit), .act(act),
    .held_vld(held_vld), .held_data(held_data), .held_chan(held_chan)
  );

  ar_pick #(.DATA_W(DATA_W)) u_pick (
    .first_data(held_data), .second_data(in_data),
    .pick_data(pick_data), .pick_range(pick_range), .below_thr(below_thr)
  );

  always_comb begin
    ld_data  = in_data;
    ld_chan  = in_chan;
    ld_range = in_gain;
    ld_err   = 1'b0;
    case (act)
      ACT_ORPHAN: begin
        ld_range = GAIN_X10;
        ld_err   = 1'b1;
      end
      ACT_RESOLVE: begin
        ld_data  = pick_data;
        ld_chan  = held_chan;
        ld_range = pick_range;
      end
      ACT_FLUSH: begin
        ld_data  = held_data;
        ld_chan  = held_chan;
        ld_range = GAIN_UNITY;
        ld_err   = 1'b1;
      end
      default: ;
    endcase
  end

  ar_out_stage #(.DATA_W(DATA_W), .CH_W(CH_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .ld_data(ld_data), .ld_chan(ld_chan),
    .ld_range(ld_range), .ld_err(ld_err), .out_ready(out_ready),
    .slot_free(slot_free), .out_valid(out_valid), .out_data(out_data),
    .out_chan(out_chan), .out_range(out_range), .out_err(out_err)
  );

  assign pass_fire    = emit && act == ACT_PASS;
  assign orphan_fire  = emit && act == ACT_ORPHAN;
  assign resolve_fire = emit && act == ACT_RESOLVE;
  assign flush_fire   = emit && act == ACT_FLUSH;

  AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    pass_fire |=> out_valid && out_data == $past(in_data) && !out_err &&
                  out_range == $past(in_gain)); // R2
  AST_RESOLVE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_fire |=> !out_err && out_chan == $past(held_chan) &&
                     (out_range ? out_data == $past(in_data)
                                : out_data == $past(held_data))); // R4
  AST_FLUSH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |=> out_err && !out_range && out_data == $past(held_data) && !held_vld); // R6
  AST_ORPHAN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_fire |=> out_err && out_range && !held_vld); // R8
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && act != ACT_HOLD |=> out_valid); // R10
  AST_SIGN_THR: assert property (@(posedge clk) disable iff (!rst_n)
    held_vld && held_data == $signed({1'b1, {(DATA_W-1){1'b0}}}) |-> !below_thr); // R5
endmodule

// File: tb/test_autorange_pair_sel.sv
`timescale 1ns/1ps
module test_autorange_pair_sel;
  localparam int DW = 12;
  localparam int CW = 4;
  localparam int LIMIT = 2047 / 10;

  typedef struct {
    logic signed [DW-1:0] d;
    logic [CW-1:0]        c;
    logic                 r;
    logic                 e;
    string                req;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_gain = 0, in_pair = 0, out_ready = 0;
  logic signed [DW-1:0] in_data = '0;
  logic [CW-1:0] in_chan = '0;
  logic in_ready, out_valid, out_range, out_err;
  logic signed [DW-1:0] out_data;
  logic [CW-1:0] out_chan;

  int total = 0, bad = 0, cyc = 0, rdy_mode = 0;
  exp_t q[$];
  bit m_held = 0;
  logic signed [DW-1:0] m_hd;
  logic [CW-1:0] m_hc;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  autorange_pair_sel #(.DATA_W(DW), .CH_W(CW)) i_autorange_pair_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .in_gain(in_gain), .in_pair(in_pair),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .out_range(out_range), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic push(input logic signed [DW-1:0] d, input logic [CW-1:0] c,
                      input logic r, input logic e, input string req);
    exp_t x;
    x.d = d; x.c = c; x.r = r; x.e = e; x.req = req;
    q.push_back(x);
  endtask

  // reference model of the requirements
  task automatic model(input logic signed [DW-1:0] d, input logic [CW-1:0] c,
                       input logic g, input logic p, input string brk_req);
    int a;
    if (m_held && !(p && g && c == m_hc)) begin
      push(m_hd, m_hc, 1'b0, 1'b1, brk_req);          // R6 / R7
      m_held = 0;
    end
    if (m_held) begin
      a = (m_hd < 0) ? -int'(m_hd) : int'(m_hd);
      if (a < LIMIT) push(d, m_hc, 1'b1, 1'b0, "R4");
      else           push(m_hd, m_hc, 1'b0, 1'b0, "R5");
      m_held = 0;
    end else if (p && !g) begin
      m_held = 1; m_hd = d; m_hc = c;                 // R3
    end else if (p && g) begin
      push(d, c, 1'b1, 1'b1, "R8");
    end else begin
      push(d, c, g, 1'b0, "R2");
    end
  endtask

  task automatic send(input logic signed [DW-1:0] d, input logic [CW-1:0] c,
                      input logic g, input logic p, input string brk_req);
    model(d, c, g, p, brk_req);
    @(negedge clk);
    in_valid = 1; in_data = d; in_chan = c; in_gain = g; in_pair = p;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: out_ready = 1;
      1: out_ready = cyc[0] ^ cyc[2];
      default: out_ready = 0;
    endcase
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(0, "R9 unexpected result", out_data, 0);
      end else begin
        exp_t x;
        x = q.pop_front();
        chk(out_data == x.d && out_chan == x.c && out_range == x.r && out_err == x.e,
            x.req, {out_err, out_range, out_chan, out_data},
            {x.e, x.r, x.c, x.d});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired, pending=%0d", q.size());
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic signed [DW-1:0] held_out;
    repeat (3) @(negedge clk);
    #1 chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    #1 chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);

    // R1/R8: high-gain member first after reset is an orphan
    send(12'sd77, 4'd3, 1'b1, 1'b1, "R6");
    @(negedge clk); #1 chk(out_valid == 1, "R10 latency", out_valid, 1);

    // R2 and R10 latency of a pass-through
    send(-12'sd500, 4'd9, 1'b1, 1'b0, "R7");
    @(negedge clk); #1 chk(out_valid == 1, "R10 latency pass", out_valid, 1);

    // R3: first member gives no output
    send(12'sd100, 4'd5, 1'b0, 1'b1, "R6");
    @(negedge clk); #1 chk(out_valid == 0, "R3 no output on hold", out_valid, 0);
    send(12'sd1000, 4'd5, 1'b1, 1'b1, "R6");            // R4: |100| < 204

    // threshold corners: R4 and R5
    send(12'sd203, 4'd1, 1'b0, 1'b1, "R6");  send(12'sd2030, 4'd1, 1'b1, 1'b1, "R6");
    send(12'sd204, 4'd1, 1'b0, 1'b1, "R6");  send(12'sd2040, 4'd1, 1'b1, 1'b1, "R6");
    send(-12'sd203, 4'd2, 1'b0, 1'b1, "R6"); send(-12'sd2030, 4'd2, 1'b1, 1'b1, "R6");
    send(-12'sd204, 4'd2, 1'b0, 1'b1, "R6"); send(-12'sd2040, 4'd2, 1'b1, 1'b1, "R6");
    send(-12'sd2048, 4'd4, 1'b0, 1'b1, "R6"); send(-12'sd2048, 4'd4, 1'b1, 1'b1, "R6");
    send(12'sd0, 4'd4, 1'b0, 1'b1, "R6");    send(12'sd5, 4'd4, 1'b1, 1'b1, "R6");

    // R6: channel mismatch, then the partner is treated as orphan
    send(12'sd10, 4'd6, 1'b0, 1'b1, "R6");   send(12'sd99, 4'd7, 1'b1, 1'b1, "R6");
    // R7: pass-through cuts into a pair
    send(12'sd300, 4'd8, 1'b0, 1'b1, "R7");  send(12'sd42, 4'd8, 1'b0, 1'b0, "R7");
    // two unity members in a row: first flushed, second held
    send(12'sd11, 4'd0, 1'b0, 1'b1, "R6");   send(12'sd12, 4'd0, 1'b0, 1'b1, "R6");
    send(12'sd13, 4'd0, 1'b1, 1'b1, "R6");

    // R9: stall holds output and blocks input
    repeat (3) @(negedge clk);
    rdy_mode = 2;
    send(12'sd321, 4'd2, 1'b0, 1'b0, "R7");
    model(12'sd654, 4'd3, 1'b0, 1'b0, "R7");
    @(negedge clk);
    in_valid = 1; in_data = 12'sd654; in_chan = 4'd3; in_gain = 0; in_pair = 0;
    #1 held_out = out_data;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid == 1 && out_data == 12'sd321, "R9 output held", out_data, 321);
      chk(in_ready == 0, "R9 input stalled", in_ready, 0);
      @(negedge clk); #1;
    end
    chk(out_data == held_out, "R9 stable", out_data, held_out);
    rdy_mode = 0;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    #1 in_valid = 0;

    // mixed stream under irregular backpressure
    rdy_mode = 1;
    for (int i = 0; i < 150; i++) begin
      logic signed [DW-1:0] v1, v2;
      logic [CW-1:0] ch;
      lfsr = step(lfsr); v1 = (i % 2 == 0) ? DW'($signed({1'b0, lfsr[8:0]}) - 256) : lfsr[11:0];
      lfsr = step(lfsr); v2 = lfsr[11:0];
      ch = lfsr[15:12];
      case (i % 5)
        0: send(v1, ch, lfsr[0], 1'b0, "R7");
        1: begin send(v1, ch, 1'b0, 1'b1, "R6"); send(v2, ch, 1'b1, 1'b1, "R6"); end
        2: begin send(v1, ch, 1'b0, 1'b1, "R6"); send(v2, ch + 4'd1, 1'b1, 1'b1, "R6"); end
        3: begin send(v1, ch, 1'b0, 1'b1, "R7"); send(v2, ch, 1'b0, 1'b0, "R7"); end
        default: send(v2, ch, 1'b1, 1'b1, "R6");
      endcase
    end
    rdy_mode = 0;
    for (int w = 0; w < 2000 && q.size() != 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 all results delivered", q.size(), 0);
    #1 chk(out_valid == 0, "R9 no extra result", out_valid, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule